// File: doc/BRIEF.md
# Banked Tile Scratchpad

This block holds a 16 by 16 tile of data words in eight independent single-read, single-write banks. Each cycle it accepts one multi-lane write and one multi-lane read, both addressed by a base (row, column) pair. It turns every lane's logical coordinate into a bank number and an in-bank offset. It then steers write data into the banks and sends bank outputs back to the read lanes in request order. No bank is ever asked for two words in one cycle, so neither port stalls.

The layout is set at elaboration by the `DIAG` parameter. With `DIAG = 0`, the tile is split two ways across rows and four ways across columns. This lets a compute engine read a block of two rows by four adjacent columns in one cycle, and write the same shape. With `DIAG = 1`, the banks are skewed along anti-diagonals. A loader can then write eight adjacent columns of one row at once, and a compute engine can read one column from two consecutive rows at once. This uses eight banks where a plain two-by-eight split would need sixteen. Row and column arithmetic wraps modulo 16, so any base position is legal.

Top module: `scratchTile`

## Requirements
- R1: The tile holds 16 x 16 words of `DW` bits in 8 banks of 32 words each. Lane `l` of `wrData` and `rdData` occupies bits `[l*DW +: DW]`, for lanes 0 to 7.
- R2: With `DIAG = 0`, a read at base (r, c) returns on lane `l` the word at row `(r + l/4) mod 16` and column `(c + l mod 4) mod 16`.
- R3: With `DIAG = 0`, a write at base (r, c) stores lane `l` at row `(r + l/4) mod 16` and column `(c + l mod 4) mod 16`.
- R4: With `DIAG = 1`, a write at base (r, c) stores lane `l` at row `r` and column `(c + l) mod 16`.
- R5: With `DIAG = 1`, a read at base (r, c) returns on lanes 0 and 1 the words at rows `r` and `(r + 1) mod 16` of column `c`. Lanes 2 to 7 read as zero.
- R6: With `DIAG = 0`, a word sits in bank `(row mod 2)*4 + (col mod 4)` at offset `(row/2)*4 + col/4`. The active lanes of any read or write touch pairwise distinct banks.
- R7: With `DIAG = 1`, a word sits in bank `(row + col) mod 8` at offset `row*2 + col/8`. The active lanes of any read or write touch pairwise distinct banks.
- R8: `rdValid` is high exactly in the cycle after a cycle with `rdEn` high, and read data is presented in that same cycle.
- R9: After reset, and in every cycle where `rdValid` is low, `rdData` is all zeros.
- R10: When a read and a write touch the same word in the same cycle, the read returns the contents from before the write.
- R11: While `wrEn` is low, the tile contents do not change, whatever the write address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request for this cycle |
| wrRow | input | 4 | Base row of the write pattern |
| wrCol | input | 4 | Base column of the write pattern |
| wrData | input | 8*DW | Write lanes, lane 0 in the low bits |
| rdEn | input | 1 | Read request for this cycle |
| rdRow | input | 4 | Base row of the read pattern |
| rdCol | input | 4 | Base column of the read pattern |
| rdValid | output | 1 | Read data is valid in this cycle |
| rdData | output | 8*DW | Read lanes, lane 0 in the low bits |

## Verification
The bench builds two instances side by side with `DW = 16`: one with `DIAG = 0` and one with `DIAG = 1`. Both are driven with the same stimulus, so every write and read exercises both bank layouts at once. After a full fill, a sweep reads back every one of the 256 base positions, including those that wrap past row 15 and column 15. A bank collision in either mapping would show up there as a lost or misrouted word. Directed cases then cover writes at wrapping bases, a read and a write to the same word in one cycle, ignored writes, and idle output.

// File: rtl/scratchPkg.sv
package scratchPkg;
  // tile geometry
  localparam int ROWS   = 16;
  localparam int COLS   = 16;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  // lane and bank geometry
  localparam int LANES  = 8;
  localparam int NBANK  = 8;
  localparam int BANK_W = $clog2(NBANK);
  localparam int DEPTH  = (ROWS * COLS) / NBANK;
  localparam int OFF_W  = $clog2(DEPTH);
  // block-split factors
  localparam int HROW   = 2;
  localparam int HCOL   = NBANK / HROW;
  // lanes used by a column read in skewed layout
  localparam int DCOL_LANES = 2;

  typedef struct packed {
    logic rdFire;
    logic wrFire;
  } strobeT;

  function automatic logic [BANK_W-1:0] hierBank(logic [ROW_W-1:0] r, logic [COL_W-1:0] c);
    int unsigned v;
    v = (int'(r) % HROW) * HCOL + (int'(c) % HCOL);
    return BANK_W'(v);
  endfunction

  function automatic logic [OFF_W-1:0] hierOff(logic [ROW_W-1:0] r, logic [COL_W-1:0] c);
    int unsigned v;
    v = (int'(r) / HROW) * (COLS / HCOL) + (int'(c) / HCOL);
    return OFF_W'(v);
  endfunction

  function automatic logic [BANK_W-1:0] diagBank(logic [ROW_W-1:0] r, logic [COL_W-1:0] c);
    int unsigned v;
    v = (int'(r) + int'(c)) % NBANK;
    return BANK_W'(v);
  endfunction

  function automatic logic [OFF_W-1:0] diagOff(logic [ROW_W-1:0] r, logic [COL_W-1:0] c);
    int unsigned v;
    v = int'(r) * (COLS / NBANK) + (int'(c) / NBANK);
    return OFF_W'(v);
  endfunction
endpackage

// File: rtl/laneMap.sv
module laneMap
  import scratchPkg::*;
#(
  parameter bit DIAG    = 1'b0,
  parameter bit IS_READ = 1'b0
) (
  input  logic [ROW_W-1:0]               baseRow,
  input  logic [COL_W-1:0]               baseCol,
  output logic [LANES-1:0][BANK_W-1:0]   laneBank,
  output logic [LANES-1:0][OFF_W-1:0]    laneOff,
  output logic [LANES-1:0]               laneAct
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ROW_W-1:0] r;
    logic [COL_W-1:0] c;
    if (!DIAG) begin : g_block
      // two-row by four-column footprint, wrapping on both axes
      assign r = baseRow + ROW_W'(l / HCOL);
      assign c = baseCol + COL_W'(l % HCOL);
      assign laneAct[l]  = 1'b1;
      assign laneBank[l] = hierBank(r, c);
      assign laneOff[l]  = hierOff(r, c);
    end else if (IS_READ) begin : g_colRead
      // consecutive rows of one column
      assign r = baseRow + ROW_W'(l);
      assign c = baseCol;
      assign laneAct[l]  = (l < DCOL_LANES);
      assign laneBank[l] = diagBank(r, c);
      assign laneOff[l]  = diagOff(r, c);
    end else begin : g_rowWrite
      // adjacent columns of one row
      assign r = baseRow;
      assign c = baseCol + COL_W'(l);
      assign laneAct[l]  = 1'b1;
      assign laneBank[l] = diagBank(r, c);
      assign laneOff[l]  = diagOff(r, c);
    end
  end
endmodule

// File: rtl/scratchCtrl.sv
module scratchCtrl
  import scratchPkg::*;
#(
  parameter bit DIAG = 1'b0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ROW_W-1:0]               wrRow,
  input  logic [COL_W-1:0]               wrCol,
  input  logic                           rdEn,
  input  logic [ROW_W-1:0]               rdRow,
  input  logic [COL_W-1:0]               rdCol,
  output strobeT                         strobe,
  output logic [LANES-1:0][BANK_W-1:0]   wrLaneBank,
  output logic [LANES-1:0][OFF_W-1:0]    wrLaneOff,
  output logic [LANES-1:0]               wrLaneAct,
  output logic [LANES-1:0][BANK_W-1:0]   rdLaneBank,
  output logic [LANES-1:0][OFF_W-1:0]    rdLaneOff,
  output logic [LANES-1:0]               rdLaneAct,
  output logic [LANES-1:0][BANK_W-1:0]   rdLaneBankQ,
  output logic [LANES-1:0]               rdLaneActQ,
  output logic                           rdValidQ
);
  laneMap #(.DIAG(DIAG), .IS_READ(1'b0)) u_wrMap (
    .baseRow (wrRow),
    .baseCol (wrCol),
    .laneBank(wrLaneBank),
    .laneOff (wrLaneOff),
    .laneAct (wrLaneAct)
  );

  laneMap #(.DIAG(DIAG), .IS_READ(1'b1)) u_rdMap (
    .baseRow (rdRow),
    .baseCol (rdCol),
    .laneBank(rdLaneBank),
    .laneOff (rdLaneOff),
    .laneAct (rdLaneAct)
  );

  assign strobe.rdFire = rdEn;
  assign strobe.wrFire = wrEn;

  // remember which bank feeds each lane for the return cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ    <= 1'b0;
      rdLaneBankQ <= '0;
      rdLaneActQ  <= '0;
    end else begin
      rdValidQ <= rdEn;
      if (rdEn) begin
        rdLaneBankQ <= rdLaneBank;
        rdLaneActQ  <= rdLaneAct;
      end
    end
  end
endmodule

// File: rtl/scratchBanks.sv
module scratchBanks
  import scratchPkg::*;
#(
  parameter int DW = 16
) (
  input  logic                           clk,
  input  strobeT                         strobe,
  input  logic [LANES-1:0][BANK_W-1:0]   wrLaneBank,
  input  logic [LANES-1:0][OFF_W-1:0]    wrLaneOff,
  input  logic [LANES-1:0]               wrLaneAct,
  input  logic [LANES*DW-1:0]            wrData,
  input  logic [LANES-1:0][BANK_W-1:0]   rdLaneBank,
  input  logic [LANES-1:0][OFF_W-1:0]    rdLaneOff,
  input  logic [LANES-1:0]               rdLaneAct,
  input  logic [LANES-1:0][BANK_W-1:0]   rdLaneBankQ,
  input  logic [LANES-1:0]               rdLaneActQ,
  input  logic                           rdValidQ,
  output logic [LANES*DW-1:0]            rdData
);
  logic [NBANK-1:0][DW-1:0] bankOut;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0]    store [DEPTH];
    logic             wHit, rHit;
    logic [OFF_W-1:0] wOff, rOff;
    logic [DW-1:0]    wDat;
    logic [DW-1:0]    q;

    // gather the lane aimed at this bank; the mapping allows at most one
    always_comb begin
      wHit = 1'b0;
      wOff = '0;
      wDat = '0;
      rHit = 1'b0;
      rOff = '0;
      for (int l = 0; l < LANES; l++) begin
        if (wrLaneAct[l] && (wrLaneBank[l] == BANK_W'(b))) begin
          wHit = 1'b1;
          wOff = wrLaneOff[l];
          wDat = wrData[l*DW +: DW];
        end
        if (rdLaneAct[l] && (rdLaneBank[l] == BANK_W'(b))) begin
          rHit = 1'b1;
          rOff = rdLaneOff[l];
        end
      end
    end

    // read samples the old word when both ports hit the same entry
    always_ff @(posedge clk) begin
      if (strobe.wrFire && wHit) store[wOff] <= wDat;
      if (strobe.rdFire && rHit) q <= store[rOff];
    end

    assign bankOut[b] = q;
  end

  // return crossbar: each lane picks the bank recorded at request time
  for (genvar l = 0; l < LANES; l++) begin : g_ret
    assign rdData[l*DW +: DW] = (rdValidQ && rdLaneActQ[l]) ? bankOut[rdLaneBankQ[l]] : '0;
  end
endmodule

// File: rtl/scratchTile.sv
module scratchTile
  import scratchPkg::*;
#(
  parameter int DW   = 16,
  parameter bit DIAG = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ROW_W-1:0]      wrRow,
  input  logic [COL_W-1:0]      wrCol,
  input  logic [LANES*DW-1:0]   wrData,
  input  logic                  rdEn,
  input  logic [ROW_W-1:0]      rdRow,
  input  logic [COL_W-1:0]      rdCol,
  output logic                  rdValid,
  output logic [LANES*DW-1:0]   rdData
);
  strobeT                        strobe;
  logic [LANES-1:0][BANK_W-1:0]  wrLaneBank, rdLaneBank, rdLaneBankQ;
  logic [LANES-1:0][OFF_W-1:0]   wrLaneOff, rdLaneOff;
  logic [LANES-1:0]              wrLaneAct, rdLaneAct, rdLaneActQ;
  logic                          rdValidQ;

  scratchCtrl #(.DIAG(DIAG)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrRow      (wrRow),
    .wrCol      (wrCol),
    .rdEn       (rdEn),
    .rdRow      (rdRow),
    .rdCol      (rdCol),
    .strobe     (strobe),
    .wrLaneBank (wrLaneBank),
    .wrLaneOff  (wrLaneOff),
    .wrLaneAct  (wrLaneAct),
    .rdLaneBank (rdLaneBank),
    .rdLaneOff  (rdLaneOff),
    .rdLaneAct  (rdLaneAct),
    .rdLaneBankQ(rdLaneBankQ),
    .rdLaneActQ (rdLaneActQ),
    .rdValidQ   (rdValidQ)
  );

  scratchBanks #(.DW(DW)) u_banks (
    .clk        (clk),
    .strobe     (strobe),
    .wrLaneBank (wrLaneBank),
    .wrLaneOff  (wrLaneOff),
    .wrLaneAct  (wrLaneAct),
    .wrData     (wrData),
    .rdLaneBank (rdLaneBank),
    .rdLaneOff  (rdLaneOff),
    .rdLaneAct  (rdLaneAct),
    .rdLaneBankQ(rdLaneBankQ),
    .rdLaneActQ (rdLaneActQ),
    .rdValidQ   (rdValidQ),
    .rdData     (rdData)
  );

  assign rdValid = rdValidQ;
endmodule

// File: rtl/scratchTileChk.sv
module scratchTileChk
  import scratchPkg::*;
#(
  parameter int DW   = 16,
  parameter bit DIAG = 1'b0
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           rdEn,
  input logic                           wrEn,
  input logic                           rdValid,
  input logic [LANES*DW-1:0]            rdData,
  input logic [LANES-1:0][BANK_W-1:0]   rdLaneBank,
  input logic [LANES-1:0]               rdLaneAct,
  input logic [LANES-1:0][BANK_W-1:0]   wrLaneBank,
  input logic [LANES-1:0]               wrLaneAct
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [LANES-1:0] rdHit, wrHit;
    always_comb begin
      for (int l = 0; l < LANES; l++) begin
        rdHit[l] = rdLaneAct[l] && (rdLaneBank[l] == BANK_W'(b));
        wrHit[l] = wrLaneAct[l] && (wrLaneBank[l] == BANK_W'(b));
      end
    end

    // R6 R7
    rd_bank_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
      rdEn |-> $onehot0(rdHit));

    // R6 R7
    wr_bank_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrEn |-> $onehot0(wrHit));
  end

  // R8
  rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  // R8
  rd_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  if (DIAG) begin : g_diag
    // R5
    upper_lane_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      rdData[LANES*DW-1:DCOL_LANES*DW] == '0);
  end
endmodule

bind scratchTile scratchTileChk #(.DW(DW), .DIAG(DIAG)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdEn      (rdEn),
  .wrEn      (wrEn),
  .rdValid   (rdValid),
  .rdData    (rdData),
  .rdLaneBank(rdLaneBank),
  .rdLaneAct (rdLaneAct),
  .wrLaneBank(wrLaneBank),
  .wrLaneAct (wrLaneAct)
);

// File: tb/scratchTile_tb.sv
module scratchTile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int L  = 8;
  localparam int W  = L * DW;
  localparam int NVEC = 8;
  // write-then-read bases {row, col}; several wrap past the tile edge
  localparam logic [7:0] VEC [NVEC] = '{
    8'hFE, 8'hFF, 8'h79, 8'h0C, 8'hE0, 8'h3D, 8'hF0, 8'h8F
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] wrRow = '0, wrCol = '0, rdRow = '0, rdCol = '0;
  logic [W-1:0] wrData = '0;
  logic hValid, dValid;
  logic [W-1:0] hData, dData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DW-1:0] refH [16][16];
  logic [DW-1:0] refD [16][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  scratchTile #(.DW(DW), .DIAG(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRow(wrRow), .wrCol(wrCol), .wrData(wrData),
    .rdEn(rdEn), .rdRow(rdRow), .rdCol(rdCol), .rdValid(hValid), .rdData(hData)
  );

  scratchTile #(.DW(DW), .DIAG(1'b1)) u_dutDiag (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRow(wrRow), .wrCol(wrCol), .wrData(wrData),
    .rdEn(rdEn), .rdRow(rdRow), .rdCol(rdCol), .rdValid(dValid), .rdData(dData)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expBlock(input int r, input int c);
    logic [W-1:0] v;
    for (int l = 0; l < L; l++) v[l*DW +: DW] = refH[(r + l/4) % 16][(c + l%4) % 16];
    return v;
  endfunction

  function automatic logic [W-1:0] expSkew(input int r, input int c);
    logic [W-1:0] v;
    v = '0;
    for (int l = 0; l < 2; l++) v[l*DW +: DW] = refD[(r + l) % 16][c];
    return v;
  endfunction

  // one cycle: optional write and read; read result checked on both instances
  task automatic access(input bit we, input int wr, input int wc, input logic [W-1:0] wd,
                        input bit re, input int rr, input int rc, input string tag);
    logic [W-1:0] eH, eD;
    eH = expBlock(rr, rc);
    eD = expSkew(rr, rc);
    wrEn = we; wrRow = 4'(wr); wrCol = 4'(wc); wrData = wd;
    rdEn = re; rdRow = 4'(rr); rdCol = 4'(rc);
    @(posedge clk);
    if (we) begin
      for (int l = 0; l < L; l++) begin
        refH[(wr + l/4) % 16][(wc + l%4) % 16] = wd[l*DW +: DW];
        refD[wr][(wc + l) % 16] = wd[l*DW +: DW];
      end
    end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    if (re) begin
      chk(hValid === 1'b1 && hData === eH, {tag, " block"}, hData, eH);
      chk(dValid === 1'b1 && dData === eD, {tag, " skew"}, dData, eD);
    end
  endtask

  function automatic logic [W-1:0] pat(input int seed);
    logic [W-1:0] v;
    for (int l = 0; l < L; l++) v[l*DW +: DW] = DW'(seed * 8 + l + 16'h1000);
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(hValid === 1'b0 && hData === '0, "R9 reset block", hData, '0);
    chk(dValid === 1'b0 && dData === '0, "R9 reset skew", dData, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 fill in block footprints, then R4 fill in row strips
    for (int r = 0; r < 16; r += 2)
      for (int c = 0; c < 16; c += 4) begin
        access(1'b1, r, c, pat(seed), 1'b0, 0, 0, "R3 fill");
        seed++;
      end
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c += 8) begin
        access(1'b1, r, c, pat(seed), 1'b0, 0, 0, "R4 fill");
        seed++;
      end

    // R1 R2 R5 R6 R7 R8: every base position, both layouts
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        access(1'b0, 0, 0, '0, 1'b1, r, c, "R2 R5 R6 R7 R8 sweep");

    // table of wrapping write bases, each read back at the same base
    for (int i = 0; i < NVEC; i++) begin
      access(1'b1, int'(VEC[i][7:4]), int'(VEC[i][3:0]), pat(seed), 1'b0, 0, 0, "R3 R4 vec");
      seed++;
      access(1'b0, 0, 0, '0, 1'b1, int'(VEC[i][7:4]), int'(VEC[i][3:0]), "R3 R4 vec readback");
    end

    // R10 same word written and read in one cycle returns old contents
    access(1'b1, 4, 4, pat(777), 1'b1, 4, 4, "R10 collide");
    access(1'b0, 0, 0, '0, 1'b1, 4, 4, "R10 after");

    // R11 write inputs toggled with wrEn low
    wrData = {W{1'b1}}; wrRow = 4'd2; wrCol = 4'd2;
    @(negedge clk);
    access(1'b0, 2, 2, {W{1'b1}}, 1'b0, 0, 0, "R11 idle");
    access(1'b0, 0, 0, '0, 1'b1, 2, 2, "R11 readback");

    // R9 idle cycle after a read
    @(negedge clk);
    chk(hValid === 1'b0 && hData === '0, "R9 idle block", hData, '0);
    chk(dValid === 1'b0 && dData === '0, "R9 idle skew", dData, '0);

    // R5 upper lanes of a column read are zero
    access(1'b0, 0, 0, '0, 1'b1, 15, 9, "R5 column wrap");
    rdEn = 1'b1; rdRow = 4'd6; rdCol = 4'd3;
    @(negedge clk);
    rdEn = 1'b0;
    chk(dData[W-1:2*DW] === '0, "R5 upper lanes", dData, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule